// File: doc/BRIEF.md
# Sticky Right Shifter for a Double-Word Significand

This block shifts a double-width value right by an unsigned amount. The value arrives as two words, an upper and a lower half. Any set bit pushed off the bottom is not simply dropped. The bits that fall off are OR-ed together, and that single flag is merged into bit 0 of the result. A later rounding stage can then still tell an exact result from an inexact one. Typical users are floating-point datapaths. There the product or the smaller addend is aligned to the other operand's exponent before the add.

Every count the shift-count port can carry is accepted. Counts at or beyond the full width reduce the value to a single "anything was set" flag. The shift itself is pure combinational logic. A parameter places one register stage after it, which gives a latency of one clock. With that parameter cleared, the result follows the inputs directly. Rounding, normalisation and exponent arithmetic belong to the surrounding datapath.

Top module: `sticky_rshift`

## Requirements
- R1: A shift count of 0 returns both words unchanged, and no sticky bit is added.
- R2: For a count k from 1 to 63, the upper output is the upper input shifted right by k. The lower output is bits [k+63:k] of the concatenation {upper, lower}. Its bit 0 is OR-ed with the OR of the k lowest bits of the lower input.
- R3: For a count of exactly 64, the upper output is zero. The lower output is the upper input, with bit 0 OR-ed with the OR of all 64 bits of the lower input.
- R4: For a count k from 65 to 127, the upper output is zero. The lower output is the upper input shifted right by k-64. Its bit 0 is OR-ed with the OR of the k-64 lowest bits of the upper input and with the OR of the whole lower input.
- R5: For any count of 128 or more, up to the largest value of the 8-bit count port (255), the upper output is zero. The lower output is 1 when any of the 128 input bits is set and 0 otherwise.
- R6: The sticky flag is OR-ed into bit 0 and never replaces it. When no set bit is lost, a bit 0 of 1 that was shifted into place stays 1. When set bits are lost, bit 0 is 1 even if the bit shifted into place is 0.
- R7: With the output register enabled (the default), a result appears on the outputs one rising clock edge after its inputs are applied. While the active-low asynchronous reset is low, both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low, clears the output register |
| hi_i | input | 64 | Upper word of the value to shift |
| lo_i | input | 64 | Lower word of the value to shift |
| shamt_i | input | 8 | Unsigned right-shift count |
| hi_o | output | 64 | Upper word of the shifted result |
| lo_o | output | 64 | Lower word of the shifted result, sticky flag merged into bit 0 |

## Verification
Every count from 0 to 200 is driven with random words and with every one of the 128 single-bit values. The single-bit values separate the four count ranges exactly: each input bit either lands in place, is absorbed into the sticky flag, or vanishes. An off-by-one in any range boundary or mask therefore shows up. Directed cases cover the remaining corners. An all-zero value at the maximum count must give zero. An all-ones value must keep bit 0 set without creating extra bits. A lone bit 0 lost at count 1 must still produce the flag. Further directed cases check the one-cycle latency and that an asynchronous reset clears the outputs while it is held.

// File: rtl/sticky_shr_pkg.sv
package sticky_shr_pkg;

    // Which path of the shifter handles a given count.
    typedef enum logic [1:0] {
        SPAN_LOW   = 2'd0,  // count below one word width
        SPAN_HIGH  = 2'd1,  // count from one word width up to full width - 1
        SPAN_FLUSH = 2'd2   // count at or beyond the full width
    } span_e;

endpackage

// File: rtl/sticky_shr_span.sv
module sticky_shr_span
    import sticky_shr_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int CNT_W  = 8,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [CNT_W-1:0] shamt,
    output span_e            span,
    output logic [IDX_W-1:0] sub_amt
);
    localparam int FULL_W = 2 * WORD_W;
    localparam logic [CNT_W:0] FULL_C = (CNT_W+1)'(FULL_W);
    localparam logic [CNT_W:0] WORD_C = (CNT_W+1)'(WORD_W);

    logic [CNT_W:0] cnt_ext;

    always_comb begin
        cnt_ext = {1'b0, shamt};
        // Word width is a power of two, so the in-word remainder is the low bits.
        sub_amt = shamt[IDX_W-1:0];
        if (cnt_ext >= FULL_C) begin
            span = SPAN_FLUSH;
        end else if (cnt_ext >= WORD_C) begin
            span = SPAN_HIGH;
        end else begin
            span = SPAN_LOW;
        end
    end

endmodule

// File: rtl/sticky_shr_mask.sv
module sticky_shr_mask #(
    parameter int WORD_W = 64,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [IDX_W-1:0]  amt,
    output logic [WORD_W-1:0] mask
);
    // Thermometer mask: bit b is set when b is below the shift amount.
    // Built bit by bit so that no shift by a full word width is ever formed.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign mask[b] = (IDX_W'(b) < amt);
    end

endmodule

// File: rtl/sticky_shr_low.sv
module sticky_shr_low #(
    parameter int WORD_W = 64,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] hi,
    input  logic [WORD_W-1:0] lo,
    input  logic [IDX_W-1:0]  amt,
    output logic [WORD_W-1:0] hi_res,
    output logic [WORD_W-1:0] lo_res
);
    logic [2*WORD_W-1:0] cat_s;
    logic [WORD_W-1:0]   lost_m;
    logic                sticky;

    sticky_shr_mask #(.WORD_W(WORD_W)) u_mask (
        .amt  (amt),
        .mask (lost_m)
    );

    always_comb begin
        // Shift the joined pair: the upper word's low bits move into the lower word.
        cat_s  = {hi, lo} >> amt;
        sticky = |(lo & lost_m);
        hi_res = cat_s[2*WORD_W-1:WORD_W];
        lo_res = cat_s[WORD_W-1:0] | {{(WORD_W-1){1'b0}}, sticky};
    end

endmodule

// File: rtl/sticky_shr_high.sv
module sticky_shr_high #(
    parameter int WORD_W = 64,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] hi,
    input  logic [WORD_W-1:0] lo,
    input  logic [IDX_W-1:0]  amt,
    output logic [WORD_W-1:0] lo_res
);
    logic [WORD_W-1:0] lost_m;
    logic              sticky;

    sticky_shr_mask #(.WORD_W(WORD_W)) u_mask (
        .amt  (amt),
        .mask (lost_m)
    );

    always_comb begin
        // amt is the count minus one word width; the whole lower word is lost.
        sticky = (|lo) | (|(hi & lost_m));
        lo_res = (hi >> amt) | {{(WORD_W-1){1'b0}}, sticky};
    end

endmodule

// File: rtl/sticky_rshift.sv
module sticky_rshift
    import sticky_shr_pkg::*;
#(
    parameter int WORD_W  = 64,
    parameter int CNT_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] hi_i,
    input  logic [WORD_W-1:0] lo_i,
    input  logic [CNT_W-1:0]  shamt_i,
    output logic [WORD_W-1:0] hi_o,
    output logic [WORD_W-1:0] lo_o
);
    localparam int IDX_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } pair_t;

    span_e             span_s;
    logic [IDX_W-1:0]  sub_amt_s;
    logic [WORD_W-1:0] low_hi_s;
    logic [WORD_W-1:0] low_lo_s;
    logic [WORD_W-1:0] high_lo_s;
    logic              any_set_s;

    pair_t res_d;
    pair_t res_q;

    sticky_shr_span #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_span (
        .shamt   (shamt_i),
        .span    (span_s),
        .sub_amt (sub_amt_s)
    );

    sticky_shr_low #(.WORD_W(WORD_W)) u_low (
        .hi     (hi_i),
        .lo     (lo_i),
        .amt    (sub_amt_s),
        .hi_res (low_hi_s),
        .lo_res (low_lo_s)
    );

    sticky_shr_high #(.WORD_W(WORD_W)) u_high (
        .hi     (hi_i),
        .lo     (lo_i),
        .amt    (sub_amt_s),
        .lo_res (high_lo_s)
    );

    always_comb begin
        any_set_s = (|hi_i) | (|lo_i);
        res_d     = '0;
        unique case (span_s)
            SPAN_LOW: begin
                res_d.hi = low_hi_s;
                res_d.lo = low_lo_s;
            end
            SPAN_HIGH: begin
                res_d.hi = '0;
                res_d.lo = high_lo_s;
            end
            default: begin
                res_d.hi = '0;
                res_d.lo = {{(WORD_W-1){1'b0}}, any_set_s};
            end
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign hi_o = res_q.hi;
    assign lo_o = res_q.lo;

endmodule

// File: rtl/sticky_rshift_chk.sv
module sticky_rshift_chk #(
    parameter int WORD_W  = 64,
    parameter int CNT_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] hi_i,
    input logic [WORD_W-1:0] lo_i,
    input logic [CNT_W-1:0]  shamt_i,
    input logic [WORD_W-1:0] hi_o,
    input logic [WORD_W-1:0] lo_o
);
    localparam int FULL_W = 2 * WORD_W;
    localparam logic [CNT_W:0] FULL_C = (CNT_W+1)'(FULL_W);
    localparam logic [CNT_W:0] WORD_C = (CNT_W+1)'(WORD_W);

    logic [WORD_W-1:0] hi_s;
    logic [WORD_W-1:0] lo_s;
    logic [CNT_W-1:0]  sh_s;
    logic              primed;
    logic [FULL_W-1:0] full_s;
    logic [FULL_W-1:0] lost_m;
    logic              lost_any;
    logic              flush_s;

    // Inputs aligned with the outputs they produced.
    if (REG_OUT) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_s   <= '0;
                lo_s   <= '0;
                sh_s   <= '0;
                primed <= 1'b0;
            end else begin
                hi_s   <= hi_i;
                lo_s   <= lo_i;
                sh_s   <= shamt_i;
                primed <= 1'b1;
            end
        end
    end else begin : g_pass
        assign hi_s   = hi_i;
        assign lo_s   = lo_i;
        assign sh_s   = shamt_i;
        assign primed = 1'b1;
    end

    always_comb begin
        full_s   = {hi_s, lo_s};
        flush_s  = ({1'b0, sh_s} >= FULL_C);
        lost_m   = flush_s ? '1 : ((FULL_W'(1) << sh_s) - FULL_W'(1));
        lost_any = |(full_s & lost_m);
    end

    assert_zero_count_R1: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (sh_s == '0) |-> (hi_o == hi_s && lo_o == lo_s));

    // Clean shifts (no bit lost) must be exact: R2, R3, R4.
    assert_clean_exact_R2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        (!lost_any && !flush_s) |-> ({hi_o, lo_o} == (full_s >> sh_s)));

    // Upper word empty for counts of a word or more: R3, R4, R5.
    assert_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        ({1'b0, sh_s} >= WORD_C) |-> (hi_o == '0));

    assert_flush_flag_R5: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        flush_s |-> (lo_o == {{(WORD_W-1){1'b0}}, |full_s}));

    assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        lost_any |-> lo_o[0]);

endmodule

bind sticky_rshift sticky_rshift_chk #(
    .WORD_W  (WORD_W),
    .CNT_W   (CNT_W),
    .REG_OUT (REG_OUT)
) u_chk (.*);

// File: tb/tb_sticky_rshift.sv
`timescale 1ns/1ps
module tb_sticky_rshift;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  hi_i = '0;
    logic [63:0]  lo_i = '0;
    logic [7:0]   shamt_i = '0;
    logic [63:0]  hi_o;
    logic [63:0]  lo_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    sticky_rshift dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_i    (hi_i),
        .lo_i    (lo_i),
        .shamt_i (shamt_i),
        .hi_o    (hi_o),
        .lo_o    (lo_o)
    );

    // Reference: shift the 128-bit value, OR every lost bit into bit 0.
    function automatic logic [127:0] ref_shift(logic [63:0] h, logic [63:0] l, int sh);
        logic [127:0] v;
        logic [127:0] r;
        logic         st;
        v  = {h, l};
        st = 1'b0;
        if (sh >= 128) begin
            r = {127'b0, |v};
        end else begin
            for (int b = 0; b < sh; b++) st |= v[b];
            r = v >> sh;
            r[0] = r[0] | st;
        end
        return r;
    endfunction

    function automatic string req_of(int sh);
        if (sh == 0)  return "R1";
        if (sh < 64)  return "R2";
        if (sh == 64) return "R3";
        if (sh < 128) return "R4";
        return "R5";
    endfunction

    task automatic check(string req, logic [127:0] got, logic [127:0] exp, string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Apply at a falling edge, compare at the next falling edge (one register).
    task automatic apply(logic [63:0] h, logic [63:0] l, int sh, string req);
        hi_i    = h;
        lo_i    = l;
        shamt_i = 8'(sh);
        @(negedge clk);
        check(req, {hi_o, lo_o}, ref_shift(h, l, sh), $sformatf("shift %0d", sh));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // R7: outputs held at zero while reset is low, whatever the inputs.
        hi_i = 64'hFFFF_0000_1234_5678;
        lo_i = 64'h0F0F_0F0F_0F0F_0F0F;
        shamt_i = 8'd3;
        repeat (3) @(negedge clk);
        check("R7", {hi_o, lo_o}, 128'b0, "during reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R7: latency of one clock edge.
        apply(64'h1, 64'h2, 0, "R1");
        hi_i = 64'hAAAA_AAAA_AAAA_AAAA;
        lo_i = 64'h5555_5555_5555_5555;
        shamt_i = 8'd4;
        #1;
        check("R7", {hi_o, lo_o}, ref_shift(64'h1, 64'h2, 0), "before edge");
        @(negedge clk);
        check("R7", {hi_o, lo_o}, ref_shift(64'hAAAA_AAAA_AAAA_AAAA,
              64'h5555_5555_5555_5555, 4), "after edge");

        // Directed corners.
        apply(64'h0, 64'h0, 255, "R5");                       // nothing set: zero
        apply(64'h0, 64'h1, 255, "R5");                       // single low bit: flag
        apply(64'h8000_0000_0000_0000, 64'h0, 128, "R5");
        apply('1, '1, 0, "R1");
        apply('1, '1, 64, "R3");
        apply(64'h0, 64'h1, 1, "R6");                         // lost bit sets flag
        apply(64'h0, 64'h2, 1, "R6");                         // in-place bit kept, no loss
        apply(64'h0, 64'h3, 1, "R6");                         // both: bit 0 still 1, bit 1 clear
        apply(64'h1234_5678_9ABC_DEF0, 64'h0, 64, "R3");      // no lost bits at 64
        apply(64'h1234_5678_9ABC_DEF0, 64'h1, 64, "R3");
        apply(64'h3, 64'h0, 65, "R4");
        apply(64'h8000_0000_0000_0000, 64'h0, 127, "R4");

        // Sweep counts 0..200 with random words and single-bit values.
        for (int sh = 0; sh <= 200; sh++) begin
            for (int k = 0; k < 6; k++) apply(rnd64(), rnd64(), sh, req_of(sh));
            for (int b = 0; b < 128; b++) begin
                logic [127:0] one;
                one = 128'b1 << b;
                apply(one[127:64], one[63:0], sh, req_of(sh));
            end
        end

        // R7: asynchronous reset clears the outputs without a clock edge.
        apply(rnd64(), 64'hFFFF, 8, "R2");
        #1 rst_n = 1'b0;
        #0.5;
        check("R7", {hi_o, lo_o}, 128'b0, "async reset");
        @(negedge clk);
        rst_n = 1'b1;
        apply(64'hDEAD_BEEF_0000_0001, 64'h0, 63, "R2");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule